// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This block sits in front of a single-precision arithmetic unit that adds, subtracts, multiplies and divides. Each accepted request carries two 32-bit operands and a 2-bit operation code. The block sorts every operand into zero, subnormal, normal, infinity or NaN. It then decides whether the special-case rules alone fix the answer. When they do, it raises `bypass` and presents the final result word and its exception flags. The downstream datapath then skips the arithmetic. When they do not, `bypass` stays low and the request continues down the ordinary path.

The answer comes from a fixed set of special operand pairs. The block never performs the arithmetic itself. The operand class decode is written once and instantiated per operand. A rule stage combines the two classes with the operation. One register stage presents the outcome. The field widths are parameters, and the defaults give the single-precision layout.

Top module: `fpsr_resolver`

## Requirements
- R1: Operand class comes from the exponent field (bits 30:23) and the fraction field (bits 22:0). Exponent 0 with fraction 0 is a zero. Exponent 0 with a nonzero fraction is a subnormal, which counts as finite and nonzero. Exponent 255 with fraction 0 is an infinity. Exponent 255 with a nonzero fraction is a NaN, which is signalling when fraction bit 22 is 0 and quiet when it is 1.
- R2: A request presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high for exactly that one cycle.
- R3: If either operand is a NaN, the block bypasses with result 0x7FC00000 for any operation. `flag_invalid` is raised only when at least one NaN operand is signalling.
- R4: Operation codes are 00 add, 01 subtract, 10 multiply and 11 divide. For add and subtract, a subtract uses operand B with its sign inverted. Two infinities of equal effective sign give that infinity. Two infinities of opposite effective sign give 0x7FC00000 with `flag_invalid`. A single infinity gives that infinity with its effective sign. Finite operands are not bypassed.
- R5: For multiply, infinity times zero (in either order) gives 0x7FC00000 with `flag_invalid`. Infinity times any non-zero operand gives infinity. Zero times a finite operand gives zero. The sign of these results is the XOR of the operand signs, and finite nonzero pairs are not bypassed.
- R6: For divide, zero divided by zero and infinity divided by infinity give 0x7FC00000 with `flag_invalid`. A finite nonzero operand divided by zero gives infinity and raises `flag_divzero`. Infinity divided by anything else gives infinity without `flag_divzero`. A finite operand divided by infinity gives zero, and so does zero divided by a finite nonzero operand. All these result signs are the XOR of the operand signs, and finite nonzero pairs are not bypassed.
- R7: A subnormal operand raises `flag_denorm` in every case. A subnormal operand never forces `bypass` by itself.
- R8: When `bypass` is low, `result` is 0 and both `flag_invalid` and `flag_divzero` are 0.
- R9: While `rst_n` is low, `out_valid`, `bypass`, `result` and all flags are 0.
- R10: In cycles without a new request, `bypass`, `result` and the flags keep their last values, whatever the operand and operation inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation: 00 add, 01 sub, 10 mul, 11 div |
| opnd_a | input | 32 | Operand A, single precision |
| opnd_b | input | 32 | Operand B, single precision |
| out_valid | output | 1 | Outcome of the previous cycle's request is present |
| bypass | output | 1 | Result fully determined by special cases |
| result | output | 32 | Final result word when bypassing, else 0 |
| flag_invalid | output | 1 | Invalid operation |
| flag_divzero | output | 1 | Finite nonzero divided by zero |
| flag_denorm | output | 1 | A subnormal operand was seen |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that an invalid flag always comes with the quiet NaN word and bypass;
- that a zero-divide flag always comes with a bypassed infinity;
- that a non-bypassed outcome carries a zero word and no invalid or zero-divide flags;
- that a subnormal on either input port raises the subnormal flag.

The assertions cannot tell whether a given operand pair should have been bypassed at all, or which sign the result should carry. Those parts of the rule set are shown only by the bench's directed scenarios. The same holds for the split between signalling and quiet NaNs and for the effective-sign handling of subtraction.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } fpsr_op_t;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
    logic is_snan;
  } fpsr_cls_t;

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fpsr_cls_t             cls
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_lo, exp_hi, frac_nil;

  assign exp_f    = word[WORD_W-2 -: EXP_W];
  assign frac_f   = word[FRAC_W-1:0];
  assign exp_lo   = (exp_f == '0);
  assign exp_hi   = &exp_f;
  assign frac_nil = (frac_f == '0);

  always_comb begin
    cls.sign    = word[WORD_W-1];
    cls.is_zero = exp_lo & frac_nil;
    cls.is_sub  = exp_lo & ~frac_nil;
    cls.is_inf  = exp_hi & frac_nil;
    cls.is_nan  = exp_hi & ~frac_nil;
    cls.is_snan = exp_hi & ~frac_nil & ~frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fpsr_rules.sv
module fpsr_rules
  import fpsr_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  fpsr_cls_t             cls_a,
  input  fpsr_cls_t             cls_b,
  input  fpsr_op_t              op,
  output logic                  take,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                  inv,
  output logic                  dz,
  output logic                  sub_seen
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] QNAN_W =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [WORD_W-1:0] inf_w(input logic s);
    inf_w = {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] zero_w(input logic s);
    zero_w = {s, {(WORD_W-1){1'b0}}};
  endfunction

  logic s_prod, s_beff;

  assign s_prod   = cls_a.sign ^ cls_b.sign;
  assign s_beff   = cls_b.sign ^ (op == OP_SUB);
  assign sub_seen = cls_a.is_sub | cls_b.is_sub;

  always_comb begin
    take = 1'b0;
    word = '0;
    inv  = 1'b0;
    dz   = 1'b0;
    if (cls_a.is_nan || cls_b.is_nan) begin
      take = 1'b1;
      word = QNAN_W;
      inv  = cls_a.is_snan | cls_b.is_snan;
    end else begin
      case (op)
        OP_ADD, OP_SUB: begin
          if (cls_a.is_inf && cls_b.is_inf) begin
            take = 1'b1;
            if (cls_a.sign == s_beff) begin
              word = inf_w(cls_a.sign);
            end else begin
              word = QNAN_W;
              inv  = 1'b1;
            end
          end else if (cls_a.is_inf) begin
            take = 1'b1;
            word = inf_w(cls_a.sign);
          end else if (cls_b.is_inf) begin
            take = 1'b1;
            word = inf_w(s_beff);
          end
        end
        OP_MUL: begin
          if ((cls_a.is_inf && cls_b.is_zero) || (cls_a.is_zero && cls_b.is_inf)) begin
            take = 1'b1;
            word = QNAN_W;
            inv  = 1'b1;
          end else if (cls_a.is_inf || cls_b.is_inf) begin
            take = 1'b1;
            word = inf_w(s_prod);
          end else if (cls_a.is_zero || cls_b.is_zero) begin
            take = 1'b1;
            word = zero_w(s_prod);
          end
        end
        OP_DIV: begin
          if ((cls_a.is_zero && cls_b.is_zero) || (cls_a.is_inf && cls_b.is_inf)) begin
            take = 1'b1;
            word = QNAN_W;
            inv  = 1'b1;
          end else if (cls_a.is_inf) begin
            take = 1'b1;
            word = inf_w(s_prod);
          end else if (cls_b.is_inf) begin
            take = 1'b1;
            word = zero_w(s_prod);
          end else if (cls_b.is_zero) begin
            take = 1'b1;
            word = inf_w(s_prod);
            dz   = 1'b1;
          end else if (cls_a.is_zero) begin
            take = 1'b1;
            word = zero_w(s_prod);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpsr_resolver.sv
module fpsr_resolver
  import fpsr_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            op_sel,
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  output logic                  out_valid,
  output logic                  bypass,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flag_invalid,
  output logic                  flag_divzero,
  output logic                  flag_denorm
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned N_OPND = 2;
  localparam logic [WORD_W-1:0] QNAN_W =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] opnd [N_OPND];
  fpsr_cls_t         cls  [N_OPND];

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    fpsr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (opnd[gi]),
      .cls  (cls[gi])
    );
  end

  logic              r_take, r_inv, r_dz, r_sub;
  logic [WORD_W-1:0] r_word;

  fpsr_rules #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rules (
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .op       (fpsr_op_t'(op_sel)),
    .take     (r_take),
    .word     (r_word),
    .inv      (r_inv),
    .dz       (r_dz),
    .sub_seen (r_sub)
  );

  // next-state
  logic              vld_d, byp_d, inv_d, dz_d, den_d;
  logic [WORD_W-1:0] res_d;

  always_comb begin
    vld_d = in_valid;
    byp_d = bypass;
    res_d = result;
    inv_d = flag_invalid;
    dz_d  = flag_divzero;
    den_d = flag_denorm;
    if (in_valid) begin
      byp_d = r_take;
      res_d = r_word;
      inv_d = r_inv;
      dz_d  = r_dz;
      den_d = r_sub;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      bypass       <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_divzero <= 1'b0;
      flag_denorm  <= 1'b0;
    end else begin
      out_valid    <= vld_d;
      bypass       <= byp_d;
      result       <= res_d;
      flag_invalid <= inv_d;
      flag_divzero <= dz_d;
      flag_denorm  <= den_d;
    end
  end

  // checks
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_invalid_qnan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (bypass && result == QNAN_W));
  assert_divzero_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_divzero |-> (bypass && result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  assert_denorm_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opnd_a[WORD_W-2 -: EXP_W] == '0 && opnd_a[FRAC_W-1:0] != '0) |=> flag_denorm);
  assert_denorm_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opnd_b[WORD_W-2 -: EXP_W] == '0 && opnd_b[FRAC_W-1:0] != '0) |=> flag_denorm);
  assert_quiet_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> (result == '0 && !flag_invalid && !flag_divzero));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(bypass)));
endmodule

// File: tb/fpsr_resolver_test.sv
module fpsr_resolver_test;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001;
  localparam logic [31:0] ONE  = 32'h3F800000, TWO  = 32'h40000000;
  localparam logic [31:0] NTWO = 32'hC0000000, PZ   = 32'h00000000;
  localparam logic [31:0] NZ   = 32'h80000000, DEN  = 32'h00000001;
  localparam logic [1:0]  ADD = 2'b00, SUB = 2'b01, MUL = 2'b10, DIV = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic out_valid, bypass, flag_invalid, flag_divzero, flag_denorm;
  logic [31:0] result;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  fpsr_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .bypass(bypass),
    .result(result), .flag_invalid(flag_invalid), .flag_divzero(flag_divzero),
    .flag_denorm(flag_denorm)
  );

  task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h (byp,inv,dz,den,result)", req, got, exp);
    end
  endtask

  // one request, then compare the outcome {bypass,inv,dz,den,result}
  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] op, input logic [35:0] exp);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {35'd0, out_valid}, 36'd1);
    chk(req, {bypass, flag_invalid, flag_divzero, flag_denorm, result}, exp);
  endtask

  task automatic t_reset();
    chk("R9 reset", {bypass, flag_invalid, flag_divzero, flag_denorm, result}, 36'd0);
    chk("R9 reset valid", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic t_timing();
    run("R2 req", ONE, PINF, ADD, {4'b1000, PINF});
    @(negedge clk);
    chk("R2 one-cycle valid", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic t_hold();
    run("R10 setup", ONE, PZ, DIV, {4'b1010, PINF});
    opnd_a = SNAN; opnd_b = DEN; op_sel = MUL;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold", {bypass, flag_invalid, flag_divzero, flag_denorm, result}, {4'b1010, PINF});
  endtask

  task automatic t_nan();
    run("R3 qnan add", QNAN, ONE, ADD, {4'b1000, QNAN});
    run("R3 snan mul", ONE, SNAN, MUL, {4'b1100, QNAN});
    run("R3 neg qnan div", 32'hFFC00001, PZ, DIV, {4'b1000, QNAN});
    run("R1 snan not inf", SNAN, PINF, ADD, {4'b1100, QNAN});
  endtask

  task automatic t_add();
    run("R4 inf+inf", PINF, PINF, ADD, {4'b1000, PINF});
    run("R4 inf-inf", PINF, PINF, SUB, {4'b1100, QNAN});
    run("R4 inf+-inf", PINF, NINF, ADD, {4'b1100, QNAN});
    run("R4 -inf-inf", NINF, PINF, SUB, {4'b1000, NINF});
    run("R4 1+-inf", ONE, NINF, ADD, {4'b1000, NINF});
    run("R4 1--inf", ONE, NINF, SUB, {4'b1000, PINF});
    run("R4 finite add", ONE, TWO, ADD, {4'b0000, PZ});
  endtask

  task automatic t_mul();
    run("R5 inf*0", PINF, PZ, MUL, {4'b1100, QNAN});
    run("R5 0*-inf", PZ, NINF, MUL, {4'b1100, QNAN});
    run("R5 -inf*-2", NINF, NTWO, MUL, {4'b1000, PINF});
    run("R5 inf*inf", PINF, PINF, MUL, {4'b1000, PINF});
    run("R5 -0*1", NZ, ONE, MUL, {4'b1000, NZ});
    run("R5 finite mul", ONE, NTWO, MUL, {4'b0000, PZ});
  endtask

  task automatic t_div();
    run("R6 0/0", PZ, NZ, DIV, {4'b1100, QNAN});
    run("R6 inf/-inf", PINF, NINF, DIV, {4'b1100, QNAN});
    run("R6 -2/0", NTWO, PZ, DIV, {4'b1010, NINF});
    run("R6 1/-0", ONE, NZ, DIV, {4'b1010, NINF});
    run("R6 inf/0", PINF, PZ, DIV, {4'b1000, PINF});
    run("R6 -inf/2", NINF, TWO, DIV, {4'b1000, NINF});
    run("R6 1/-inf", ONE, NINF, DIV, {4'b1000, NZ});
    run("R6 0/-2", PZ, NTWO, DIV, {4'b1000, NZ});
    run("R6 finite div", ONE, TWO, DIV, {4'b0000, PZ});
  endtask

  task automatic t_denorm();
    run("R7 den*1", DEN, ONE, MUL, {4'b0001, PZ});
    run("R7 den/0", DEN, PZ, DIV, {4'b1011, PINF});
    run("R7 den+qnan", DEN, QNAN, ADD, {4'b1001, QNAN});
    run("R1 den*inf nonzero", DEN, PINF, MUL, {4'b1001, PINF});
    run("R8 den-1 no bypass", ONE, DEN, SUB, {4'b0001, PZ});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_timing();
    t_nan();
    t_add();
    t_mul();
    t_div();
    t_denorm();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule